// File: doc/BRIEF.md
# PWM Time-Base Counter with Two-Stage Prescaler

This block produces the timing reference for a pulse-width modulator. A module-clock enable is divided by a two-stage prescaler; every prescaled tick steps a 16-bit counter that runs upward, downward, up and down in a triangle, or stays frozen. The counter's limit is an active period value, loaded either directly from a write or from a shadow copy that is copied in only when the count next arrives at zero. This lets a new period take effect at a cycle boundary without a glitch.

Downstream compare and action logic uses the outputs. These are the count value, the direction of the last step, and two single-cycle event strobes that mark the count arriving at zero and arriving at the period value. A halt input models a debugger stop. A two-bit run-mode field decides whether the counter obeys the halt after one more step, at the end of the current cycle, or not at all. One write port carries two targets: the control word (select 0) and the period value (select 1).

Top module: `pwm_timebase`

## Requirements
- R1: After reset the count is 0, both strobes are low, the direction flag is 1, and the control word holds freeze mode, both divider fields at 0, run mode 00 and shadow loading. The active period and the shadow period are both 0.
- R2: Control word bits: [1:0] counter mode, [2] period immediate load, [5:3] base divider exponent, [8:6] high-speed divider, [10:9] run mode. Counter mode 00 counts up from 0 to the active period P, then returns to 0. A count above P also returns to 0. The direction flag is 1.
- R3: Counter mode 01 counts down. From 0 it reloads P, then decrements to 0. The direction flag is 0.
- R4: Counter mode 10 counts 0,1,…,P,P-1,…,0 and repeats, so one cycle is 2P ticks. The direction flag shows the direction of the step that produced the current count.
- R5: Counter mode 11 freezes the count, and no strobe fires.
- R6: The prescaled tick comes every 2^E × H enabled clock cycles. E is the base exponent. H is 1 when the high-speed field is 0, and 2×N for a field value N. Cycles with the clock enable low do not count. A control write restarts the prescaler.
- R7: With bit [2]=0, a period write goes to the shadow copy. That copy becomes active only on the step where the count becomes 0.
- R8: With bit [2]=1, a period write updates the active period in the next cycle.
- R9: The zero strobe is high for exactly one clock, in the first cycle the count holds 0 after a step. The period strobe does the same for the active period value. When P is 0, both fire on every step.
- R10: Run mode 00: while halt is high the counter takes at most one more step, then holds until halt falls.
- R11: Run mode 01: while halt is high the counter keeps stepping until the count is 0, then holds until halt falls.
- R12: Run modes 10 and 11 ignore halt.
- R13: Count and period are 16 bits wide. A period of 0xFFFF runs the count up to 0xFFFF and then wraps it to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_en_i | input | 1 | Module clock enable feeding the prescaler |
| halt_i | input | 1 | Debug halt request |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 1 | Write target: 0 control word, 1 period |
| wr_data_i | input | 16 | Write data |
| count_o | output | 16 | Current count |
| dir_up_o | output | 1 | 1 when the last step was upward |
| zero_hit_o | output | 1 | One-clock strobe when the count arrives at 0 |
| prd_hit_o | output | 1 | One-clock strobe when the count arrives at the period |

## Verification
The bench builds the block with its default parameters: a 16-bit count and 3-bit divider fields. That width lets a run of 65,535 steps test the full-scale wrap at 0xFFFF directly. The prescale is checked for ratios of 2, 4 and 12. Each of these ratios exercises a different stage or both stages together. The same divider widths would also allow ratios up to 1792, but the bench does not test those. Since the period is 16 bits, the bench can also test a shadowed period smaller than the running count, and see that the count passes the new value and wraps only at the old one.

// File: rtl/pwm_tb_pkg.sv
package pwm_tb_pkg;

    localparam int EXP_W  = 3;
    localparam int HS_W   = 3;
    localparam int CTRL_W = 2 + 1 + EXP_W + HS_W + 2;

    typedef enum logic [1:0] {
        CM_UP     = 2'b00,
        CM_DOWN   = 2'b01,
        CM_UPDOWN = 2'b10,
        CM_FREEZE = 2'b11
    } cnt_mode_e;

    typedef enum logic [1:0] {
        RM_STEP  = 2'b00,
        RM_CYCLE = 2'b01,
        RM_FREE  = 2'b10,
        RM_FREEX = 2'b11
    } run_mode_e;

    typedef struct packed {
        run_mode_e         run;
        logic [HS_W-1:0]   hs_div;
        logic [EXP_W-1:0]  exp_div;
        logic              imm_load;
        cnt_mode_e         mode;
    } ctrl_t;

    localparam ctrl_t CTRL_RESET = '{
        run:      RM_STEP,
        hs_div:   '0,
        exp_div:  '0,
        imm_load: 1'b0,
        mode:     CM_FREEZE
    };

endpackage

// File: rtl/pwm_tb_prescaler.sv
module pwm_tb_prescaler #(
    parameter int EXP_W = 3,
    parameter int HS_W  = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic             restart_i,
    input  logic [EXP_W-1:0] exp_i,
    input  logic [HS_W-1:0]  hs_i,
    output logic             tick_o
);
    localparam int C1_W = HS_W + 1;
    localparam int C2_W = (1 << EXP_W) - 1;
    localparam logic [C1_W-1:0] C1_ONE = {{(C1_W-1){1'b0}}, 1'b1};
    localparam logic [C2_W-1:0] C2_ONE = {{(C2_W-1){1'b0}}, 1'b1};

    typedef struct packed {
        logic [C1_W-1:0] c1;
        logic [C2_W-1:0] c2;
    } ps_state_t;

    ps_state_t s_d, s_q;
    logic [C1_W-1:0] r1_last;
    logic [C2_W-1:0] r2_last;
    logic            carry1;
    logic            tick;

    always_comb begin
        r1_last = (hs_i == '0) ? '0 : ({hs_i, 1'b0} - C1_ONE);
        r2_last = ~({C2_W{1'b1}} << exp_i);
        carry1  = en_i && (s_q.c1 >= r1_last);
        tick    = carry1 && (s_q.c2 >= r2_last);
        s_d     = s_q;
        if (restart_i) begin
            s_d.c1 = '0;
            s_d.c2 = '0;
        end else if (en_i) begin
            s_d.c1 = carry1 ? '0 : s_q.c1 + C1_ONE;
            if (carry1) begin
                s_d.c2 = tick ? '0 : s_q.c2 + C2_ONE;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign tick_o = tick;

    p_tick_gap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_o && !restart_i && r1_last != '0) |=> !tick_o);

endmodule

// File: rtl/pwm_tb_period.sv
module pwm_tb_period #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_i,
    input  logic             imm_i,
    input  logic [CNT_W-1:0] data_i,
    input  logic             at_zero_i,
    output logic [CNT_W-1:0] active_o
);
    typedef struct packed {
        logic [CNT_W-1:0] shadow;
        logic [CNT_W-1:0] active;
    } prd_state_t;

    prd_state_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (at_zero_i) begin
            s_d.active = s_q.shadow;
        end
        if (wr_i) begin
            s_d.shadow = data_i;
            if (imm_i) begin
                s_d.active = data_i;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign active_o = s_q.active;

    p_imm_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && imm_i) |=> (active_o == $past(data_i)));

    p_shadow_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!at_zero_i && !(wr_i && imm_i)) |=> $stable(active_o));

endmodule

// File: rtl/pwm_tb_counter.sv
module pwm_tb_counter
    import pwm_tb_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             halt_i,
    input  cnt_mode_e        mode_i,
    input  run_mode_e        run_i,
    input  logic [CNT_W-1:0] period_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             dir_up_o,
    output logic             zero_o,
    output logic             prd_o,
    output logic             at_zero_o
);
    localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             dir_up;
        logic             step_used;
        logic             zero;
        logic             prd;
    } cnt_state_t;

    cnt_state_t       s_d, s_q;
    logic             allow;
    logic             adv;
    logic [CNT_W-1:0] nxt;
    logic             ndir;

    always_comb begin
        nxt  = s_q.cnt;
        ndir = s_q.dir_up;
        unique case (mode_i)
            CM_UP: begin
                nxt  = (s_q.cnt >= period_i) ? '0 : s_q.cnt + ONE;
                ndir = 1'b1;
            end
            CM_DOWN: begin
                nxt  = (s_q.cnt == '0) ? period_i : s_q.cnt - ONE;
                ndir = 1'b0;
            end
            CM_UPDOWN: begin
                if (s_q.dir_up) begin
                    if (s_q.cnt >= period_i) begin
                        if (s_q.cnt != '0) begin
                            nxt  = s_q.cnt - ONE;
                            ndir = 1'b0;
                        end
                    end else begin
                        nxt = s_q.cnt + ONE;
                    end
                end else begin
                    if (s_q.cnt == '0) begin
                        if (period_i != '0) begin
                            nxt  = ONE;
                            ndir = 1'b1;
                        end
                    end else begin
                        nxt = s_q.cnt - ONE;
                    end
                end
            end
            default: begin
                nxt  = s_q.cnt;
                ndir = s_q.dir_up;
            end
        endcase

        allow = !halt_i
             || (run_i == RM_FREE) || (run_i == RM_FREEX)
             || ((run_i == RM_STEP)  && !s_q.step_used)
             || ((run_i == RM_CYCLE) && (s_q.cnt != '0));
        adv   = tick_i && (mode_i != CM_FREEZE) && allow;

        s_d      = s_q;
        s_d.zero = 1'b0;
        s_d.prd  = 1'b0;
        if (!halt_i) begin
            s_d.step_used = 1'b0;
        end
        if (adv) begin
            s_d.cnt    = nxt;
            s_d.dir_up = ndir;
            s_d.zero   = (nxt == '0);
            s_d.prd    = (nxt == period_i);
            if (halt_i) begin
                s_d.step_used = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{cnt: '0, dir_up: 1'b1, step_used: 1'b0, zero: 1'b0, prd: 1'b0};
        end else begin
            s_q <= s_d;
        end
    end

    assign cnt_o     = s_q.cnt;
    assign dir_up_o  = s_q.dir_up;
    assign zero_o    = s_q.zero;
    assign prd_o     = s_q.prd;
    assign at_zero_o = adv && (nxt == '0);

    p_freeze_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == CM_FREEZE) |=> ($stable(cnt_o) && !zero_o && !prd_o));

    p_idle_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_i |=> $stable(cnt_o));

    p_step_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (halt_i && run_i == RM_STEP && s_q.step_used) |=> $stable(cnt_o));

    p_cycle_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (halt_i && run_i == RM_CYCLE && cnt_o == '0) |=> $stable(cnt_o));

    p_free_moves_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && run_i[1] && mode_i == CM_UP && period_i != '0)
            |=> (cnt_o != $past(cnt_o)));

    p_zero_strobe_r9: assert property (@(posedge clk) disable iff (!rst_n)
        zero_o |-> (cnt_o == '0));

endmodule

// File: rtl/pwm_timebase.sv
module pwm_timebase
    import pwm_tb_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clk_en_i,
    input  logic             halt_i,
    input  logic             wr_en_i,
    input  logic             wr_sel_i,
    input  logic [CNT_W-1:0] wr_data_i,
    output logic [CNT_W-1:0] count_o,
    output logic             dir_up_o,
    output logic             zero_hit_o,
    output logic             prd_hit_o
);
    localparam logic SEL_CTRL = 1'b0;
    localparam logic SEL_PRD  = 1'b1;

    ctrl_t            ctrl_d, ctrl_q;
    logic             ctrl_wr;
    logic             prd_wr;
    logic             tick;
    logic             at_zero;
    logic [CNT_W-1:0] active_prd;

    always_comb begin
        ctrl_wr = wr_en_i && (wr_sel_i == SEL_CTRL);
        prd_wr  = wr_en_i && (wr_sel_i == SEL_PRD);
        ctrl_d  = ctrl_q;
        if (ctrl_wr) begin
            ctrl_d = ctrl_t'(wr_data_i[CTRL_W-1:0]);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= CTRL_RESET;
        end else begin
            ctrl_q <= ctrl_d;
        end
    end

    pwm_tb_prescaler #(
        .EXP_W (EXP_W),
        .HS_W  (HS_W)
    ) u_prescaler (
        .clk       (clk),
        .rst_n     (rst_n),
        .en_i      (clk_en_i),
        .restart_i (ctrl_wr),
        .exp_i     (ctrl_q.exp_div),
        .hs_i      (ctrl_q.hs_div),
        .tick_o    (tick)
    );

    pwm_tb_period #(
        .CNT_W (CNT_W)
    ) u_period (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_i      (prd_wr),
        .imm_i     (ctrl_q.imm_load),
        .data_i    (wr_data_i),
        .at_zero_i (at_zero),
        .active_o  (active_prd)
    );

    pwm_tb_counter #(
        .CNT_W (CNT_W)
    ) u_counter (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_i    (tick),
        .halt_i    (halt_i),
        .mode_i    (ctrl_q.mode),
        .run_i     (ctrl_q.run),
        .period_i  (active_prd),
        .cnt_o     (count_o),
        .dir_up_o  (dir_up_o),
        .zero_o    (zero_hit_o),
        .prd_o     (prd_hit_o),
        .at_zero_o (at_zero)
    );

    p_prd_match_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (prd_hit_o && !$past(prd_wr)) |-> (count_o == active_prd));

    p_ctrl_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_wr |=> (ctrl_q == $past(wr_data_i[CTRL_W-1:0])));

endmodule

// File: tb/test_pwm_timebase.sv
module test_pwm_timebase;

    localparam logic [1:0] M_UP = 2'b00, M_DN = 2'b01, M_UD = 2'b10, M_FZ = 2'b11;
    localparam logic [1:0] R_STEP = 2'b00, R_CYC = 2'b01, R_FREE = 2'b10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        clk_en = 1'b1;
    logic        halt = 1'b0;
    logic        wr_en = 1'b0;
    logic        wr_sel = 1'b0;
    logic [15:0] wr_data = '0;
    logic [15:0] count;
    logic        dir_up, zero_hit, prd_hit;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    pwm_timebase i_pwm_timebase (
        .clk        (clk),
        .rst_n      (rst_n),
        .clk_en_i   (clk_en),
        .halt_i     (halt),
        .wr_en_i    (wr_en),
        .wr_sel_i   (wr_sel),
        .wr_data_i  (wr_data),
        .count_o    (count),
        .dir_up_o   (dir_up),
        .zero_hit_o (zero_hit),
        .prd_hit_o  (prd_hit)
    );

    function automatic logic [15:0] mk(input logic [1:0] mode, input logic imm,
                                       input logic [2:0] ex, input logic [2:0] hs,
                                       input logic [1:0] run);
        return {5'b0, run, hs, ex, imm, mode};
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic sel, input logic [15:0] d);
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic do_reset;
        halt = 1'b0; clk_en = 1'b1; wr_en = 1'b0;
        rst_n = 1'b0;
        step(2);
        rst_n = 1'b1;
        step(1);
    endtask

    task automatic setup(input logic [15:0] prd, input logic [1:0] mode,
                         input logic [2:0] ex, input logic [2:0] hs,
                         input logic [1:0] run, input logic imm);
        do_reset();
        wr(1'b0, mk(M_FZ, 1'b1, ex, hs, run));
        wr(1'b1, prd);
        wr(1'b0, mk(mode, imm, ex, hs, run));
    endtask

    task automatic t_reset;
        do_reset();
        chk("R1 count", count, 0);
        chk("R1 zero strobe", zero_hit, 0);
        chk("R1 period strobe", prd_hit, 0);
        chk("R1 dir", dir_up, 1);
        step(4);
        chk("R1 frozen after reset", count, 0);
    endtask

    task automatic t_up;
        setup(16'd4, M_UP, 3'd0, 3'd0, R_FREE, 1'b1);
        for (int j = 1; j <= 12; j++) begin
            step(1);
            chk("R2 up count", count, j % 5);
            chk("R9 zero strobe up", zero_hit, (j % 5 == 0) ? 1 : 0);
            chk("R9 period strobe up", prd_hit, (j % 5 == 4) ? 1 : 0);
        end
        chk("R2 dir up", dir_up, 1);
    endtask

    task automatic t_down;
        setup(16'd3, M_DN, 3'd0, 3'd0, R_FREE, 1'b1);
        for (int j = 1; j <= 9; j++) begin
            int e;
            e = 3 - ((j - 1) % 4);
            step(1);
            chk("R3 down count", count, e);
            chk("R3 zero strobe", zero_hit, (e == 0) ? 1 : 0);
            chk("R3 period strobe", prd_hit, (e == 3) ? 1 : 0);
        end
        chk("R3 dir", dir_up, 0);
    endtask

    task automatic t_updown;
        setup(16'd3, M_UD, 3'd0, 3'd0, R_FREE, 1'b1);
        for (int j = 1; j <= 12; j++) begin
            int m;
            m = j % 6;
            step(1);
            chk("R4 updown count", count, (m <= 3) ? m : 6 - m);
            chk("R4 updown dir", dir_up, (m >= 1 && m <= 3) ? 1 : 0);
        end
    endtask

    task automatic t_freeze;
        setup(16'd9, M_UP, 3'd0, 3'd0, R_FREE, 1'b1);
        step(3);
        wr(1'b0, mk(M_FZ, 1'b1, 3'd0, 3'd0, R_FREE));
        chk("R5 last step before freeze", count, 4);
        step(5);
        chk("R5 frozen count", count, 4);
        chk("R5 no zero strobe", zero_hit, 0);
        chk("R5 no period strobe", prd_hit, 0);
    endtask

    task automatic t_prescale;
        setup(16'd100, M_UP, 3'd1, 3'd3, R_FREE, 1'b1);
        step(11);
        chk("R6 ratio 12 before tick", count, 0);
        step(1);
        chk("R6 ratio 12 first tick", count, 1);
        step(23);
        chk("R6 ratio 12 at 35", count, 2);
        step(1);
        chk("R6 ratio 12 at 36", count, 3);
        setup(16'd1, M_UP, 3'd2, 3'd0, R_FREE, 1'b1);
        step(3);
        chk("R6 ratio 4 before tick", count, 0);
        step(1);
        chk("R6 ratio 4 first tick", count, 1);
        step(4);
        chk("R9 wrap under prescale", count, 0);
        chk("R9 zero strobe set", zero_hit, 1);
        step(1);
        chk("R9 zero strobe one clock", zero_hit, 0);
        setup(16'd100, M_UP, 3'd0, 3'd1, R_FREE, 1'b1);
        step(2);
        chk("R6 ratio 2", count, 1);
        clk_en = 1'b0;
        step(5);
        chk("R6 enable low pauses", count, 1);
        clk_en = 1'b1;
        step(2);
        chk("R6 resume after enable", count, 2);
    endtask

    task automatic t_shadow;
        setup(16'd5, M_UP, 3'd0, 3'd0, R_FREE, 1'b0);
        step(2);
        wr(1'b1, 16'd2);
        chk("R7 count at write", count, 3);
        step(2);
        chk("R7 old period still active", count, 5);
        chk("R7 old period strobe", prd_hit, 1);
        step(1);
        chk("R7 wrap", count, 0);
        step(2);
        chk("R7 new period count", count, 2);
        chk("R7 new period strobe", prd_hit, 1);
        step(1);
        chk("R7 wraps at new period", count, 0);
    endtask

    task automatic t_immediate;
        setup(16'd9, M_UP, 3'd0, 3'd0, R_FREE, 1'b1);
        step(6);
        wr(1'b1, 16'd3);
        chk("R8 count at write", count, 7);
        step(1);
        chk("R8 above new period wraps", count, 0);
        step(3);
        chk("R8 new period reached", count, 3);
        chk("R8 new period strobe", prd_hit, 1);
        step(1);
        chk("R8 wrap at new period", count, 0);
    endtask

    task automatic t_zero_period;
        setup(16'd0, M_UP, 3'd0, 3'd0, R_FREE, 1'b1);
        for (int j = 1; j <= 2; j++) begin
            step(1);
            chk("R9 zero period count", count, 0);
            chk("R9 zero period zero strobe", zero_hit, 1);
            chk("R9 zero period period strobe", prd_hit, 1);
        end
    endtask

    task automatic t_halt_step;
        setup(16'd9, M_UP, 3'd0, 3'd0, R_STEP, 1'b1);
        step(3);
        halt = 1'b1;
        step(1);
        chk("R10 one more step", count, 4);
        step(5);
        chk("R10 held", count, 4);
        halt = 1'b0;
        step(1);
        chk("R10 resumes", count, 5);
    endtask

    task automatic t_halt_cycle;
        setup(16'd5, M_UP, 3'd0, 3'd0, R_CYC, 1'b1);
        step(2);
        halt = 1'b1;
        step(3);
        chk("R11 runs to cycle end", count, 5);
        step(1);
        chk("R11 reaches zero", count, 0);
        step(4);
        chk("R11 held at zero", count, 0);
        halt = 1'b0;
        step(1);
        chk("R11 resumes", count, 1);
    endtask

    task automatic t_halt_free;
        setup(16'd5, M_UP, 3'd0, 3'd0, R_FREE, 1'b1);
        step(2);
        halt = 1'b1;
        step(3);
        chk("R12 halt ignored", count, 5);
        halt = 1'b0;
    endtask

    task automatic t_max;
        setup(16'hFFFF, M_UP, 3'd0, 3'd0, R_FREE, 1'b1);
        step(65535);
        chk("R13 full scale count", count, 65535);
        chk("R13 full scale strobe", prd_hit, 1);
        step(1);
        chk("R13 wrap to zero", count, 0);
        chk("R13 zero strobe", zero_hit, 1);
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        t_reset();
        t_up();
        t_down();
        t_updown();
        t_freeze();
        t_prescale();
        t_shadow();
        t_immediate();
        t_zero_period();
        t_halt_step();
        t_halt_cycle();
        t_halt_free();
        t_max();
        finish_run();
    end

endmodule